// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

When an exception is taken, this block saves the caller-visible context of the interrupted code. A single-cycle start pulse captures the current stack pointer, the status word, the return address, the link value, R12 and R0 to R3. The block then writes these eight words below the old stack pointer as one frame, one word per handshake beat on a data-side write port. The word order on the bus over time differs from the word order in memory. The return address and status go out first, and the argument registers follow.

At the same moment the block requests the handler entry word from the vector table over a separate instruction-side read port. Both transfers run at the same time, and a stall on one port never holds up the other.

When the last frame beat and the vector response have both been accepted, the block raises a single-cycle completion pulse. It also presents the lowered stack pointer and the fetched handler word. A start with a stack pointer that is not word aligned is rejected with an error pulse, and the block performs no bus traffic.

Top module: `exc_entry_stacker`

## Requirements
- R1: A start pulse while idle with `sp_i[1:0] == 0` makes `busy_o` high on the next cycle. `busy_o` stays high through the cycle in which the last outstanding transfer is accepted.
- R2: The frame occupies the eight words directly below the pre-entry SP. Word k lies at `SP-32+4k`, holding R0, R1, R2, R3, R12, LR, return address and status for k = 0 to 7.
- R3: Frame beats are issued in this time order: return address, status, R0, R1, R2, R3, R12, LR. The write address of each beat follows R2.
- R4: While `dw_valid_o` is high and `dw_ready_i` is low, the next cycle keeps `dw_valid_o` high with unchanged address and data. The same holds for `vf_req_o` with `vf_gnt_i` low and `vf_addr_o`.
- R5: The vector request is raised in the same first busy cycle as the first frame beat. Its address is `vec_base_i + 4*exc_num_i`.
- R6: `done_o` is a one-cycle pulse on the cycle after the later of the eighth write acceptance and the vector response (`vf_rvalid_i`). In the `done_o` cycle `busy_o` is already low.
- R7: With `done_o`, `sp_new_o` equals the pre-entry SP minus 32 (modulo 2^AW). `handler_o` equals the word returned with `vf_rvalid_i`.
- R8: A start pulse while `busy_o` is high is ignored. The running sequence keeps its captured values and no error is flagged.
- R9: A start while idle with `sp_i[1:0] != 0` gives a one-cycle `align_err_o` on the next cycle. It issues no write beat and no vector request, and `busy_o` stays low.
- R10: Each accepted sequence performs exactly eight write acceptances.
- R11: After reset, `busy_o`, `done_o`, `align_err_o`, `dw_valid_o` and `vf_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Exception accepted, begin saving context |
| sp_i | input | AW | Stack pointer before entry |
| xpsr_i | input | DW | Status word to save |
| pc_i | input | DW | Return address to save |
| lr_i | input | DW | Link value to save |
| r12_i | input | DW | R12 to save |
| r3_i | input | DW | R3 to save |
| r2_i | input | DW | R2 to save |
| r1_i | input | DW | R1 to save |
| r0_i | input | DW | R0 to save |
| vec_base_i | input | AW | Vector table base address |
| exc_num_i | input | NUM_W | Exception number indexing the table |
| dw_valid_o | output | 1 | Frame write beat valid |
| dw_addr_o | output | AW | Frame write address |
| dw_data_o | output | DW | Frame write data |
| dw_ready_i | input | 1 | Frame write beat accepted |
| vf_req_o | output | 1 | Vector read request |
| vf_addr_o | output | AW | Vector entry address |
| vf_gnt_i | input | 1 | Vector request accepted |
| vf_rvalid_i | input | 1 | Vector read data valid |
| vf_rdata_i | input | DW | Vector read data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| align_err_o | output | 1 | One-cycle misaligned stack pointer flag |
| sp_new_o | output | AW | Stack pointer after entry |
| handler_o | output | DW | Fetched handler entry word |

## Verification
The bench sweeps stack pointers, including one that wraps below address zero, against several ready-stall patterns and grant and response latencies. The sweep includes cases where the vector response arrives before, between and after the frame beats. This catches a design that waits for the fetch before stacking, since every run would then take too long. It also catches a design that raises completion after only one of the two transfers, because `done_o` would appear in the wrong cycle. Each beat is compared with the expected temporal slot and address, so a frame written in address order, or a dropped or repeated beat under stalls, shows as a data or count mismatch. Stray starts during a run and misaligned starts while idle expose a block that recaptures its inputs or writes a frame it should have refused.

// File: rtl/exc_stk_pkg.sv
package exc_stk_pkg;

    localparam int FRAME_WORDS = 8;
    localparam int SLOT_W      = $clog2(FRAME_WORDS);
    localparam int FRAME_BYTES = FRAME_WORDS * 4;

    // Slot of the return address; beats rotate from there through the frame.
    localparam logic [SLOT_W-1:0] FIRST_SLOT = SLOT_W'(6);

    typedef enum logic [1:0] {
        VF_IDLE = 2'd0,
        VF_REQ  = 2'd1,
        VF_WAIT = 2'd2
    } vf_state_e;

    // Memory slot (word offset above the new SP) written by beat number b.
    function automatic logic [SLOT_W-1:0] beat_slot(input logic [SLOT_W-1:0] b);
        return b + FIRST_SLOT;
    endfunction

endpackage

// File: rtl/stk_frame_writer.sv
module stk_frame_writer
    import exc_stk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            launch_i,
    input  logic [AW-1:0]                   base_i,
    input  logic [FRAME_WORDS-1:0][DW-1:0]  words_i,
    output logic                            valid_o,
    output logic [AW-1:0]                   addr_o,
    output logic [DW-1:0]                   data_o,
    input  logic                            ready_i,
    output logic                            last_o
);

    localparam logic [SLOT_W-1:0] LAST_BEAT = SLOT_W'(FRAME_WORDS - 1);

    typedef struct packed {
        logic              active;
        logic [SLOT_W-1:0] beat;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [SLOT_W-1:0] slot;

    always_comb begin
        st_d = st_q;
        if (launch_i) begin
            st_d.active = 1'b1;
            st_d.beat   = '0;
        end else if (st_q.active && ready_i) begin
            if (st_q.beat == LAST_BEAT) begin
                st_d.active = 1'b0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        slot    = beat_slot(st_q.beat);
        valid_o = st_q.active;
        addr_o  = base_i + (AW'(slot) << 2);
        data_o  = words_i[slot];
        last_o  = st_q.active && ready_i && (st_q.beat == LAST_BEAT);
    end

endmodule

// File: rtl/stk_vector_fetcher.sv
module stk_vector_fetcher
    import exc_stk_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic [AW-1:0] addr_i,
    output logic          req_o,
    output logic [AW-1:0] addr_o,
    input  logic          gnt_i,
    input  logic          rvalid_i,
    input  logic [DW-1:0] rdata_i,
    output logic          resp_o,
    output logic [DW-1:0] handler_o
);

    typedef struct packed {
        vf_state_e     st;
        logic [AW-1:0] addr;
        logic [DW-1:0] handler;
    } vf_regs_t;

    vf_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            VF_IDLE: begin
                if (launch_i) begin
                    r_d.st   = VF_REQ;
                    r_d.addr = addr_i;
                end
            end
            VF_REQ: begin
                if (gnt_i) begin
                    r_d.st = VF_WAIT;
                end
            end
            VF_WAIT: begin
                if (rvalid_i) begin
                    r_d.st      = VF_IDLE;
                    r_d.handler = rdata_i;
                end
            end
            default: r_d.st = VF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: VF_IDLE, addr: '0, handler: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_o     = (r_q.st == VF_REQ);
        addr_o    = r_q.addr;
        resp_o    = (r_q.st == VF_WAIT) && rvalid_i;
        handler_o = r_q.handler;
    end

endmodule

// File: rtl/exc_entry_stacker.sv
module exc_entry_stacker
    import exc_stk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int NUM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [AW-1:0]    sp_i,
    input  logic [DW-1:0]    xpsr_i,
    input  logic [DW-1:0]    pc_i,
    input  logic [DW-1:0]    lr_i,
    input  logic [DW-1:0]    r12_i,
    input  logic [DW-1:0]    r3_i,
    input  logic [DW-1:0]    r2_i,
    input  logic [DW-1:0]    r1_i,
    input  logic [DW-1:0]    r0_i,
    input  logic [AW-1:0]    vec_base_i,
    input  logic [NUM_W-1:0] exc_num_i,
    output logic             dw_valid_o,
    output logic [AW-1:0]    dw_addr_o,
    output logic [DW-1:0]    dw_data_o,
    input  logic             dw_ready_i,
    output logic             vf_req_o,
    output logic [AW-1:0]    vf_addr_o,
    input  logic             vf_gnt_i,
    input  logic             vf_rvalid_i,
    input  logic [DW-1:0]    vf_rdata_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             align_err_o,
    output logic [AW-1:0]    sp_new_o,
    output logic [DW-1:0]    handler_o
);

    typedef struct packed {
        logic                           busy;
        logic                           wr_fin;
        logic                           vf_fin;
        logic                           done;
        logic                           err;
        logic [AW-1:0]                  sp_new;
        logic [FRAME_WORDS-1:0][DW-1:0] frame;
    } ctl_t;

    ctl_t c_d, c_q;

    logic          aligned;
    logic          idle_start;
    logic          launch;
    logic [AW-1:0] vec_addr;
    logic          wr_last;
    logic          vf_resp;
    logic          wr_all;
    logic          vf_all;

    always_comb begin
        aligned    = (sp_i[1:0] == 2'b00);
        idle_start = start_i && !c_q.busy;
        launch     = idle_start && aligned;
        vec_addr   = vec_base_i + (AW'(exc_num_i) << 2);
        wr_all     = c_q.wr_fin || wr_last;
        vf_all     = c_q.vf_fin || vf_resp;

        c_d      = c_q;
        c_d.done = 1'b0;
        c_d.err  = idle_start && !aligned;

        if (launch) begin
            c_d.busy   = 1'b1;
            c_d.wr_fin = 1'b0;
            c_d.vf_fin = 1'b0;
            c_d.sp_new = sp_i - AW'(FRAME_BYTES);
            c_d.frame  = {xpsr_i, pc_i, lr_i, r12_i, r3_i, r2_i, r1_i, r0_i};
        end else if (c_q.busy) begin
            if (wr_all && vf_all) begin
                c_d.busy   = 1'b0;
                c_d.done   = 1'b1;
                c_d.wr_fin = 1'b0;
                c_d.vf_fin = 1'b0;
            end else begin
                c_d.wr_fin = wr_all;
                c_d.vf_fin = vf_all;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    stk_frame_writer #(
        .AW (AW),
        .DW (DW)
    ) u_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .base_i   (c_q.sp_new),
        .words_i  (c_q.frame),
        .valid_o  (dw_valid_o),
        .addr_o   (dw_addr_o),
        .data_o   (dw_data_o),
        .ready_i  (dw_ready_i),
        .last_o   (wr_last)
    );

    stk_vector_fetcher #(
        .AW (AW),
        .DW (DW)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch),
        .addr_i    (vec_addr),
        .req_o     (vf_req_o),
        .addr_o    (vf_addr_o),
        .gnt_i     (vf_gnt_i),
        .rvalid_i  (vf_rvalid_i),
        .rdata_i   (vf_rdata_i),
        .resp_o    (vf_resp),
        .handler_o (handler_o)
    );

    always_comb begin
        busy_o      = c_q.busy;
        done_o      = c_q.done;
        align_err_o = c_q.err;
        sp_new_o    = c_q.sp_new;
    end

endmodule

// File: rtl/stk_entry_checker.sv
module stk_entry_checker #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          align_err_o,
    input logic          dw_valid_o,
    input logic [AW-1:0] dw_addr_o,
    input logic [DW-1:0] dw_data_o,
    input logic          dw_ready_i,
    input logic          vf_req_o,
    input logic [AW-1:0] vf_addr_o,
    input logic          vf_gnt_i
);

    logic [3:0] beats_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_q <= '0;
        end else if (done_o) begin
            beats_q <= '0;
        end else if (dw_valid_o && dw_ready_i) begin
            beats_q <= beats_q + 1'b1;
        end
    end

    a_r4_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dw_valid_o && !dw_ready_i |=> dw_valid_o && $stable(dw_addr_o) && $stable(dw_data_o));

    a_r4_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        vf_req_o && !vf_gnt_i |=> vf_req_o && $stable(vf_addr_o));

    a_r5_parallel_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> dw_valid_o && vf_req_o);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !dw_valid_o && !vf_req_o);

    a_r1_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r8_no_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> !align_err_o);

    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        align_err_o |-> !busy_o && !dw_valid_o && !vf_req_o);

    a_r10_eight_beats: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> beats_q == 4'd8);

    a_r10_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
        dw_valid_o |-> beats_q < 4'd8);

endmodule

bind exc_entry_stacker stk_entry_checker #(
    .AW (AW),
    .DW (DW)
) u_stk_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .align_err_o (align_err_o),
    .dw_valid_o  (dw_valid_o),
    .dw_addr_o   (dw_addr_o),
    .dw_data_o   (dw_data_o),
    .dw_ready_i  (dw_ready_i),
    .vf_req_o    (vf_req_o),
    .vf_addr_o   (vf_addr_o),
    .vf_gnt_i    (vf_gnt_i)
);

// File: tb/tb_exc_entry_stacker.sv
module tb_exc_entry_stacker;

    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int NUM_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [AW-1:0]    sp_i = '0;
    logic [DW-1:0]    xpsr_i = '0, pc_i = '0, lr_i = '0, r12_i = '0;
    logic [DW-1:0]    r3_i = '0, r2_i = '0, r1_i = '0, r0_i = '0;
    logic [AW-1:0]    vec_base_i = '0;
    logic [NUM_W-1:0] exc_num_i = '0;
    logic             dw_valid_o;
    logic [AW-1:0]    dw_addr_o;
    logic [DW-1:0]    dw_data_o;
    logic             dw_ready_i = 1'b0;
    logic             vf_req_o;
    logic [AW-1:0]    vf_addr_o;
    logic             vf_gnt_i = 1'b0;
    logic             vf_rvalid_i = 1'b0;
    logic [DW-1:0]    vf_rdata_i = '0;
    logic             busy_o, done_o, align_err_o;
    logic [AW-1:0]    sp_new_o;
    logic [DW-1:0]    handler_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    exc_entry_stacker #(.AW(AW), .DW(DW), .NUM_W(NUM_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sp_i(sp_i),
        .xpsr_i(xpsr_i), .pc_i(pc_i), .lr_i(lr_i), .r12_i(r12_i),
        .r3_i(r3_i), .r2_i(r2_i), .r1_i(r1_i), .r0_i(r0_i),
        .vec_base_i(vec_base_i), .exc_num_i(exc_num_i),
        .dw_valid_o(dw_valid_o), .dw_addr_o(dw_addr_o), .dw_data_o(dw_data_o),
        .dw_ready_i(dw_ready_i), .vf_req_o(vf_req_o), .vf_addr_o(vf_addr_o),
        .vf_gnt_i(vf_gnt_i), .vf_rvalid_i(vf_rvalid_i), .vf_rdata_i(vf_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .align_err_o(align_err_o),
        .sp_new_o(sp_new_o), .handler_o(handler_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_val(input int run, input int slot);
        return 32'hA500_0000 ^ (32'(run) << 12) ^ (32'(slot) * 32'h0101_0011);
    endfunction

    // Word slot k of the frame: R0,R1,R2,R3,R12,LR,PC,xPSR (R2); beat b uses slot (b+6)%8 (R3).
    task automatic run_seq(input int run, input logic [31:0] sp, input int wmode,
                           input int glat, input int rlat);
        logic [31:0] base;
        logic [31:0] hval;
        logic [31:0] vexp;
        int beats, last_c, resp_c, gnt_c, done_c;
        bit granted, responded, busy_ok, err_seen;
        logic [NUM_W-1:0] num;
        num    = NUM_W'(run * 5 + 3);
        base   = (run % 2 == 0) ? 32'h0000_0000 : 32'h2000_0100;
        hval   = 32'h0000_4001 + (32'(num) << 4);
        vexp   = base + (32'(num) << 2);
        beats  = 0; last_c = -1; resp_c = -1; gnt_c = -1; done_c = -1;
        granted = 0; responded = 0; busy_ok = 1; err_seen = 0;

        @(negedge clk);
        start_i = 1'b1; sp_i = sp; vec_base_i = base; exc_num_i = num;
        r0_i = word_val(run, 0); r1_i = word_val(run, 1); r2_i = word_val(run, 2);
        r3_i = word_val(run, 3); r12_i = word_val(run, 4); lr_i = word_val(run, 5);
        pc_i = word_val(run, 6); xpsr_i = word_val(run, 7);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R1", "busy after start", 32'(busy_o), 32'd1);
        check(dw_valid_o && vf_req_o, "R5", "parallel launch",
              {30'd0, dw_valid_o, vf_req_o}, 32'd3);

        for (int c = 0; c < 300; c++) begin
            if (done_o) begin
                done_c = c;
                break;
            end
            if (!busy_o) busy_ok = 0;
            if (align_err_o) err_seen = 1;
            // data side
            dw_ready_i = (wmode == 0) ? 1'b1 : ((c % (wmode + 1)) != wmode);
            if (dw_valid_o && dw_ready_i) begin
                int slot;
                slot = (beats + 6) % 8;
                check(dw_addr_o == sp - 32 + 32'(slot) * 4, "R3", "beat address",
                      dw_addr_o, sp - 32 + 32'(slot) * 4);
                check(dw_data_o == word_val(run, slot), "R2", "beat data",
                      dw_data_o, word_val(run, slot));
                beats++;
                if (beats == 8) last_c = c;
            end
            // instruction side
            vf_gnt_i = 1'b0; vf_rvalid_i = 1'b0;
            if (vf_req_o && !granted) begin
                if (c >= glat) begin
                    vf_gnt_i = 1'b1; granted = 1; gnt_c = c;
                    check(vf_addr_o == vexp, "R5", "vector address", vf_addr_o, vexp);
                end
            end else if (granted && !responded && c == gnt_c + rlat) begin
                vf_rvalid_i = 1'b1; vf_rdata_i = hval; responded = 1; resp_c = c;
            end
            // stray start while busy (R8)
            if (c == 2) begin
                start_i = 1'b1;
                sp_i    = (run % 2 == 0) ? 32'h0000_0123 : 32'h7000_0000;
                exc_num_i = ~num;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        dw_ready_i = 1'b0; vf_gnt_i = 1'b0; vf_rvalid_i = 1'b0; start_i = 1'b0;

        check(beats == 8, "R10", "write beat count", 32'(beats), 32'd8);
        check(done_c == ((last_c > resp_c ? last_c : resp_c) + 1), "R6", "done cycle",
              32'(done_c), 32'((last_c > resp_c ? last_c : resp_c) + 1));
        check(busy_ok && busy_o == 1'b0, "R1", "busy span", {31'd0, busy_o}, 32'd0);
        check(!err_seen, "R8", "no error on busy start", {31'd0, err_seen}, 32'd0);
        check(sp_new_o == sp - 32, "R7", "new SP", sp_new_o, sp - 32);
        check(handler_o == hval, "R7", "handler word", handler_o, hval);
        @(negedge clk);
        check(done_o == 1'b0, "R6", "done one cycle", {31'd0, done_o}, 32'd0);
        @(negedge clk);
    endtask

    task automatic run_misaligned(input logic [31:0] sp);
        @(negedge clk);
        start_i = 1'b1; sp_i = sp;
        @(negedge clk);
        start_i = 1'b0;
        check(align_err_o == 1'b1, "R9", "error flag", {31'd0, align_err_o}, 32'd1);
        check(!busy_o && !dw_valid_o && !vf_req_o, "R9", "no traffic",
              {29'd0, busy_o, dw_valid_o, vf_req_o}, 32'd0);
        @(negedge clk);
        check(!align_err_o && !dw_valid_o && !vf_req_o, "R9", "error pulse and quiet",
              {29'd0, align_err_o, dw_valid_o, vf_req_o}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] sps [4];
        int          gl  [4];
        int          rl  [4];
        int          run;
        sps[0] = 32'h2000_0800; sps[1] = 32'h2000_07FC;
        sps[2] = 32'h0000_0010; sps[3] = 32'h1234_5678;
        gl[0] = 0; rl[0] = 1;
        gl[1] = 2; rl[1] = 4;
        gl[2] = 0; rl[2] = 15;
        gl[3] = 5; rl[3] = 1;
        run = 0;

        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !align_err_o && !dw_valid_o && !vf_req_o, "R11",
              "in reset", {27'd0, busy_o, done_o, align_err_o, dw_valid_o, vf_req_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !align_err_o && !dw_valid_o && !vf_req_o, "R11",
              "after reset", {27'd0, busy_o, done_o, align_err_o, dw_valid_o, vf_req_o}, 32'd0);

        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 3; w++) begin
                for (int l = 0; l < 4; l++) begin
                    run_seq(run, sps[s], w, gl[l], rl[l]);
                    run++;
                end
            end
        end

        run_misaligned(32'h2000_0801);
        run_misaligned(32'h2000_0802);
        run_misaligned(32'h2000_0803);
        run_seq(run, 32'h2000_0400, 1, 1, 2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule